// File: doc/BRIEF.md
# Asynchronous Serial Byte Receiver with Status Flags

This block takes a single asynchronous serial line at a fixed 9600 baud and turns each frame into a byte. A frame is one low start bit, eight data bits sent least significant bit first, one odd-parity bit, and one high stop bit. The line passes through a synchronizer and is sampled at sixteen times the baud rate. Each bit is taken at its centre. A start bit that has gone high again by its centre is treated as noise and dropped. A parameter for the system clock frequency sets the sampling divider.

The received byte is held in a 16-bit read-only buffer whose upper byte is always zero. Four flags report the state of the receiver. Data-ready rises when a frame completes and falls when the host pulses the buffer read strobe. Overrun marks a frame that completed while the previous byte was still unread. Framing and parity errors describe the most recent frame and are replaced when the next frame completes.

Top module: `uart_rx_core`

## Requirements
- R1: After synchronous reset, the buffer output is 0x0000 and data-ready, overrun, framing error and parity error are all 0.
- R2: After a frame completes, buffer bits 7:0 hold the eight data bits in the order they arrived, with the first received bit in bit 0. Buffer bits 15:8 always read 0.
- R3: Data-ready goes to 1 when a frame completes. It goes to 0 on the clock edge after a one-cycle high pulse on the read strobe, unless a frame completes in that same cycle.
- R4: Parity error is 1 when the eight data bits plus the parity bit contain an even number of ones. Otherwise it is 0. It keeps its value until the next frame completes.
- R5: Framing error is 1 when the stop bit reads low at its centre. It keeps its value, including across buffer reads, until the next frame completes.
- R6: Overrun is set when a frame completes while data-ready is still 1. The new byte replaces the old one. Overrun clears on a buffer read, together with data-ready.
- R7: If the read strobe and a frame completion fall in the same cycle, data-ready stays 1, overrun stays 0, and the buffer holds the new byte.
- R8: A low pulse on the line that has returned high by the start-bit centre (sample 8 of 16) starts no frame. It changes neither the buffer nor any flag.
- R9: Data, parity and stop bits are each sampled at the centre of their bit period, 16 oversampling ticks after the previous sample. The oversampling tick period is the clock frequency divided by 16 times the baud rate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| buf_rd | input | 1 | One-cycle read strobe for the receive buffer |
| rx_buf | output | 16 | Receive buffer: upper byte zero, lower byte is the last byte received |
| data_ready | output | 1 | An unread byte is in the buffer |
| overrun_err | output | 1 | A byte was overwritten before it was read |
| framing_err | output | 1 | The stop bit of the last frame was low |
| parity_err | output | 1 | The parity of the last frame was not odd |

## Verification
The hardest case to reach from the ports is a read strobe that lands in exactly the cycle a frame completes. Completion depends on the free-running oversampling phase, and the bench cannot see that phase. The bench relies on everything being deterministic after reset. It first runs a fixed schedule of two frames and records the cycle in which the buffer takes the second byte. It then resets, replays the same schedule, and raises the strobe so that it is sampled on that recorded edge. Start-bit noise, bad parity and a low stop bit are each produced directly by the serial driver. Ordinary frames sent back-to-back without reads produce the overrun case.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int OSR      = 16;
    localparam int MID_TICK = 7;
    localparam int DATA_W   = 8;
    localparam int BUF_W    = 16;
    localparam int TCNT_W   = $clog2(OSR);
    localparam int BIDX_W   = $clog2(DATA_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              parity_bad;
        logic              stop_bad;
    } rx_result_t;

    function automatic int calc_div(input int clk_hz, input int baud);
        int d;
        d = clk_hz / (baud * OSR);
        if (d < 2) d = 2;
        return d;
    endfunction

    function automatic logic parity_is_odd(input logic [DATA_W-1:0] d, input logic p);
        return ^{d, p};
    endfunction

endpackage

// File: rtl/uart_rx_tick_gen.sv
module uart_rx_tick_gen #(
    parameter int DIV = 325
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = $clog2(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == LAST) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] pipe;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) pipe[0] <= 1'b1;
                    else     pipe[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) pipe[i] <= 1'b1;
                    else     pipe[i] <= pipe[i-1];
                end
            end
        end
    endgenerate

    assign q_sync = pipe[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       line,
    output logic       done,
    output rx_result_t result
);
    localparam logic [TCNT_W-1:0] T_MID  = TCNT_W'(MID_TICK);
    localparam logic [TCNT_W-1:0] T_LAST = TCNT_W'(OSR - 1);
    localparam logic [BIDX_W-1:0] B_LAST = BIDX_W'(DATA_W - 1);

    rx_state_e         state;
    logic [TCNT_W-1:0] tcnt;
    logic [BIDX_W-1:0] bidx;
    logic [DATA_W-1:0] shreg;
    logic              par_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            tcnt    <= '0;
            bidx    <= '0;
            shreg   <= '0;
            par_bit <= 1'b0;
            done    <= 1'b0;
            result  <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (!line) begin
                        state <= ST_START;
                        tcnt  <= '0;
                    end
                end
                ST_START: if (tick) begin
                    if (tcnt == T_MID) begin
                        tcnt <= '0;
                        bidx <= '0;
                        state <= line ? ST_IDLE : ST_DATA;
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                ST_DATA: if (tick) begin
                    if (tcnt == T_LAST) begin
                        tcnt  <= '0;
                        shreg <= {line, shreg[DATA_W-1:1]};
                        if (bidx == B_LAST) state <= ST_PARITY;
                        else                bidx  <= bidx + 1'b1;
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                ST_PARITY: if (tick) begin
                    if (tcnt == T_LAST) begin
                        tcnt    <= '0;
                        par_bit <= line;
                        state   <= ST_STOP;
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                ST_STOP: if (tick) begin
                    if (tcnt == T_LAST) begin
                        tcnt              <= '0;
                        done              <= 1'b1;
                        result.data       <= shreg;
                        result.parity_bad <= !parity_is_odd(shreg, par_bit);
                        result.stop_bad   <= !line;
                        state             <= ST_IDLE;
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R8: a start bit seen high at its centre returns to idle without completing
    assert_glitch_drop_R8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_START && tick && tcnt == T_MID && line) |=> (state == ST_IDLE && !done));

    // R9: a completion only follows a stop-bit sample on a tick
    assert_done_on_tick_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(tick) && $past(state) == ST_STOP);
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
    import uart_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              done,
    input  rx_result_t        result,
    input  logic              rd,
    output logic [DATA_W-1:0] rx_byte,
    output logic              dr,
    output logic              ovr,
    output logic              fe,
    output logic              pe
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rx_byte <= '0;
            dr      <= 1'b0;
            ovr     <= 1'b0;
            fe      <= 1'b0;
            pe      <= 1'b0;
        end else if (done) begin
            rx_byte <= result.data;
            fe      <= result.stop_bad;
            pe      <= result.parity_bad;
            dr      <= 1'b1;
            ovr     <= dr && !rd;
        end else if (rd) begin
            dr  <= 1'b0;
            ovr <= 1'b0;
        end
    end

    assert_byte_load_R2: assert property (@(posedge clk) disable iff (rst)
        done |=> rx_byte == $past(result.data));

    assert_dr_set_R3: assert property (@(posedge clk) disable iff (rst)
        done |=> dr);

    assert_dr_clear_R3: assert property (@(posedge clk) disable iff (rst)
        (rd && !done) |=> (!dr && !ovr));

    assert_flags_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !done |=> ($stable(fe) && $stable(pe)));

    assert_overrun_set_R6: assert property (@(posedge clk) disable iff (rst)
        (done && dr && !rd) |=> ovr);

    assert_overrun_needs_dr_R6: assert property (@(posedge clk) disable iff (rst)
        ovr |-> dr);

    assert_same_cycle_R7: assert property (@(posedge clk) disable iff (rst)
        (done && rd) |=> (dr && !ovr));
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
    import uart_rx_pkg::*;
#(
    parameter int CLK_HZ      = 50_000_000,
    parameter int BAUD        = 9600,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_in,
    input  logic              buf_rd,
    output logic [BUF_W-1:0]  rx_buf,
    output logic              data_ready,
    output logic              overrun_err,
    output logic              framing_err,
    output logic              parity_err
);
    localparam int DIV = calc_div(CLK_HZ, BAUD);

    logic              tick;
    logic              line_s;
    logic              done;
    rx_result_t        result;
    logic [DATA_W-1:0] rx_byte;

    uart_rx_tick_gen #(.DIV(DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (rx_in),
        .q_sync  (line_s)
    );

    uart_rx_frame u_frame (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .line   (line_s),
        .done   (done),
        .result (result)
    );

    uart_rx_status u_status (
        .clk     (clk),
        .rst     (rst),
        .done    (done),
        .result  (result),
        .rd      (buf_rd),
        .rx_byte (rx_byte),
        .dr      (data_ready),
        .ovr     (overrun_err),
        .fe      (framing_err),
        .pe      (parity_err)
    );

    assign rx_buf = {{(BUF_W-DATA_W){1'b0}}, rx_byte};
endmodule

// File: tb/uart_rx_core_tb_top.sv
module uart_rx_core_tb_top;
    localparam int BAUD   = 9600;
    localparam int CLK_HZ = BAUD * 16 * 4;
    localparam int BIT_CY = 16 * 4;

    typedef struct {
        logic [7:0] data;
        logic       fe;
        logic       pe;
        logic       ovr;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_in = 1'b1;
    logic        buf_rd = 1'b0;
    logic [15:0] rx_buf;
    logic        data_ready, overrun_err, framing_err, parity_err;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit model_dr = 1'b0;
    exp_t expq[$];

    uart_rx_core #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .rx_in       (rx_in),
        .buf_rd      (buf_rd),
        .rx_buf      (rx_buf),
        .data_ready  (data_ready),
        .overrun_err (overrun_err),
        .framing_err (framing_err),
        .parity_err  (parity_err)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_cy(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; rx_in = 1'b1; buf_rd = 1'b0;
        wait_cy(4);
        rst = 1'b0;
        model_dr = 1'b0;
    endtask

    // drive one frame: start, data LSB first, parity, stop, then one idle bit
    task automatic send_raw(input logic [7:0] d, input bit bad_par, input logic stop_v);
        logic p;
        p = ~^d;
        if (bad_par) p = ~p;
        rx_in = 1'b0; wait_cy(BIT_CY);
        for (int i = 0; i < 8; i++) begin
            rx_in = d[i]; wait_cy(BIT_CY);
        end
        rx_in = p;      wait_cy(BIT_CY);
        rx_in = stop_v; wait_cy(BIT_CY);
        rx_in = 1'b1;   wait_cy(BIT_CY);
    endtask

    // driver: sends a frame and pushes the expected result for the monitor
    task automatic send_exp(input logic [7:0] d, input bit bad_par, input logic stop_v);
        exp_t e;
        send_raw(d, bad_par, stop_v);
        e.data = d;
        e.fe   = !stop_v;
        e.pe   = bad_par;
        e.ovr  = model_dr;
        model_dr = 1'b1;
        expq.push_back(e);
        wait_cy(2);
    endtask

    task automatic read_buf();
        @(negedge clk);
        buf_rd = 1'b1;
        @(negedge clk);
        buf_rd = 1'b0;
        model_dr = 1'b0;
        chk("R3 data_ready cleared by read", {31'b0, data_ready}, 0);
        chk("R6 overrun cleared by read", {31'b0, overrun_err}, 0);
    endtask

    // monitor: pops expected items and compares against the outputs
    initial begin
        forever begin
            @(negedge clk);
            if (expq.size() > 0) begin
                exp_t e;
                e = expq.pop_front();
                chk("R2 received byte", {16'b0, rx_buf}, {24'b0, e.data});
                chk("R3 data_ready after frame", {31'b0, data_ready}, 1);
                chk("R4 parity error flag", {31'b0, parity_err}, {31'b0, e.pe});
                chk("R5 framing error flag", {31'b0, framing_err}, {31'b0, e.fe});
                chk("R6 overrun flag", {31'b0, overrun_err}, {31'b0, e.ovr});
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int c_hit;
        int t0;
        do_reset();
        wait_cy(2);
        // R1 reset state
        chk("R1 buffer after reset", {16'b0, rx_buf}, 0);
        chk("R1 flags after reset",
            {28'b0, data_ready, overrun_err, framing_err, parity_err}, 0);

        // R2 R3 R9 normal frames with different patterns
        send_exp(8'h5A, 0, 1'b1); read_buf();
        send_exp(8'h01, 0, 1'b1); read_buf();
        send_exp(8'h80, 0, 1'b1); read_buf();
        send_exp(8'hFF, 0, 1'b1); read_buf();
        send_exp(8'h00, 0, 1'b1); read_buf();

        // R4 bad parity, then cleared by next good frame
        send_exp(8'h33, 1, 1'b1); read_buf();
        chk("R4 parity error held after read", {31'b0, parity_err}, 1);
        send_exp(8'hC4, 0, 1'b1); read_buf();

        // R5 low stop bit, held across read, cleared by next frame
        send_exp(8'h6E, 0, 1'b0); read_buf();
        chk("R5 framing error held after read", {31'b0, framing_err}, 1);
        send_exp(8'h17, 0, 1'b1); read_buf();

        // R6 two frames without a read
        send_exp(8'hAB, 0, 1'b1);
        send_exp(8'hCD, 0, 1'b1);
        read_buf();

        // R8 short low pulse on the line
        @(negedge clk); rx_in = 1'b0;
        wait_cy(8);
        rx_in = 1'b1;
        wait_cy(3 * BIT_CY);
        chk("R8 glitch leaves buffer", {16'b0, rx_buf}, 32'hCD);
        chk("R8 glitch leaves flags",
            {28'b0, data_ready, overrun_err, framing_err, parity_err}, 0);

        // R7 measure completion cycle of second frame after reset
        do_reset();
        t0 = cyc;
        c_hit = -1;
        fork
            begin
                send_raw(8'h3C, 0, 1'b1);
                send_raw(8'hA5, 0, 1'b1);
            end
            begin
                while (rx_buf[7:0] != 8'hA5) @(negedge clk);
                c_hit = cyc - t0;
            end
        join
        // replay with the read strobe on the completion edge
        do_reset();
        t0 = cyc;
        fork
            begin
                send_raw(8'h3C, 0, 1'b1);
                send_raw(8'hA5, 0, 1'b1);
            end
            begin
                while (cyc - t0 < c_hit - 1) @(negedge clk);
                buf_rd = 1'b1;
                @(negedge clk);
                buf_rd = 1'b0;
            end
        join
        wait_cy(2);
        chk("R7 data_ready kept on same-cycle read", {31'b0, data_ready}, 1);
        chk("R7 no overrun on same-cycle read", {31'b0, overrun_err}, 0);
        chk("R7 buffer holds new byte", {16'b0, rx_buf}, 32'hA5);

        wait_cy(4);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule